// File: doc/BRIEF.md
# Addressed Byte Store for a Two-Wire Target

This block is the storage backend behind a two-wire serial target front end. It holds 256 bytes and acts like a small serial memory chip. The front end decodes the bus and hands over a small set of events: a start event, a received byte that must be answered with an acknowledge or a refusal, and a request for the next byte to send. The block reports the bus address it answers to, built from a fixed base and a few identity strap inputs.

After a start event the first received byte is a location, not data: it loads a 9-bit pointer. Each later received byte is stored at the pointer, and the pointer then moves up by one. A transfer in the other direction streams bytes out from the pointer. The pointer never wraps. Once it holds 256, received bytes are refused and transmitted bytes read as 0xFF. A second, independent read port lets on-chip logic inspect any byte at any time.

Top module: `ee_byte_store`

## Requirements
- R1: A synchronous reset sets the pointer to 0, puts the block in an idle mode where no transfer is open, and makes every byte read as 0x00 on the host port. The cycle after reset shows no write response and no read response.
- R2: `tgt_addr` equals 0x30 plus `dev_id`, zero-extended to 7 bits. It is registered, so it is valid one cycle after `dev_id` changes.
- R3: Every `wr_valid` without `evt_start` in the same cycle gets exactly one `wr_resp` pulse on the next cycle. Every `rd_req` without `evt_start` or `wr_valid` in the same cycle gets exactly one `rd_valid` pulse on the next cycle, with `rd_data` valid in that same cycle.
- R4: After a start event, the first received byte loads the pointer (upper bit 0, lower 8 bits from the byte), is acknowledged (`wr_nack`=0), and is not stored.
- R5: In write mode, a received byte is stored at the pointer while the pointer is below 256. The byte is acknowledged, and the pointer then moves up by one.
- R6: In write mode with the pointer at 256, a received byte is refused (`wr_nack`=1) and no memory byte changes.
- R7: A read request in start mode or read mode puts the block in read mode. It returns the byte at the pointer and then moves the pointer up by one.
- R8: A read request with the pointer at 256 returns 0xFF and leaves the pointer at 256.
- R9: A read request in write mode or idle mode returns 0x00 and does not move the pointer.
- R10: A received byte in read mode or idle mode is refused (`wr_nack`=1), is not stored, and does not move the pointer.
- R11: `evt_start` takes priority: received bytes and read requests in the same cycle are dropped and get no response. When `wr_valid` and `rd_req` arrive together, only the write is served.
- R12: `host_data` shows the byte at `host_addr` one cycle later. Host reads do not change the pointer, the mode, or any response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dev_id | input | ID_W | Identity straps added to the base address |
| tgt_addr | output | 7 | Bus address the front end should answer to |
| evt_start | input | 1 | Start event pulse from the front end |
| wr_valid | input | 1 | A received byte is presented |
| wr_data | input | DATA_W | Received byte |
| wr_resp | output | 1 | Response pulse for a received byte |
| wr_nack | output | 1 | With wr_resp: 1 means refuse, 0 means acknowledge |
| rd_req | input | 1 | Request for the next byte to transmit |
| rd_valid | output | 1 | Response pulse for a read request |
| rd_data | output | DATA_W | Byte to transmit, valid with rd_valid |
| host_addr | input | ADDR_W | Host inspection address |
| host_data | output | DATA_W | Byte at host_addr, one cycle later |

## Verification
Each result appears exactly one clock after the stimulus that causes it. This holds for the write response, the read response with its data, the host-port byte and the target address. The bench drives each stimulus on a falling edge. It compares outputs at the next falling edge, so exactly one rising edge, and one register stage, lies in between. A reference model in the bench tracks the mode, the pointer and the memory contents, and it is updated at the moment of drive. This gives the expected value of each response for the one cycle in which the response is due.

// File: rtl/ebs_pkg.sv
package ebs_pkg;
  typedef enum logic [1:0] {
    M_IDLE  = 2'd0,
    M_START = 2'd1,
    M_WRITE = 2'd2,
    M_READ  = 2'd3
  } mode_t;

  typedef enum logic [1:0] {
    SRC_MEM  = 2'd0,
    SRC_FF   = 2'd1,
    SRC_ZERO = 2'd2
  } rsrc_t;
endpackage

// File: rtl/ebs_mem.sv
// Byte array with one write port and two registered read ports.
// A per-location valid bit gives a reset-cleared view without resetting the RAM.
module ebs_mem #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr_a,
  output logic [DATA_W-1:0] rdata_a,
  input  logic [ADDR_W-1:0] raddr_b,
  output logic [DATA_W-1:0] rdata_b
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] ram [DEPTH];
  logic [DEPTH-1:0]  vld;
  logic [DATA_W-1:0] ram_a_q, ram_b_q;
  logic              vld_a_q, vld_b_q;

  // RAM without reset so block RAM can be inferred
  always_ff @(posedge clk) begin
    if (we) ram[waddr] <= wdata;
    ram_a_q <= ram[raddr_a];
    ram_b_q <= ram[raddr_b];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld     <= '0;
      vld_a_q <= 1'b0;
      vld_b_q <= 1'b0;
    end else begin
      if (we) vld[waddr] <= 1'b1;
      vld_a_q <= vld[raddr_a];
      vld_b_q <= vld[raddr_b];
    end
  end

  assign rdata_a = vld_a_q ? ram_a_q : '0;
  assign rdata_b = vld_b_q ? ram_b_q : '0;
endmodule

// File: rtl/ebs_ctrl.sv
// Transfer mode and pointer sequencing for the backend handshake.
module ebs_ctrl
  import ebs_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              evt_start,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_req,
  output logic              wr_resp,
  output logic              wr_nack,
  output logic              rd_valid,
  output rsrc_t             rd_src,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output mode_t             mode,
  output logic [ADDR_W:0]   ptr
);
  localparam int PTR_W = ADDR_W + 1;

  logic at_end;
  assign at_end   = ptr[ADDR_W];
  assign mem_addr = ptr[ADDR_W-1:0];
  assign mem_we   = !evt_start && wr_valid && (mode == M_WRITE) && !at_end;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode     <= M_IDLE;
      ptr      <= '0;
      wr_resp  <= 1'b0;
      wr_nack  <= 1'b0;
      rd_valid <= 1'b0;
      rd_src   <= SRC_ZERO;
    end else begin
      wr_resp  <= 1'b0;
      wr_nack  <= 1'b0;
      rd_valid <= 1'b0;
      if (evt_start) begin
        mode <= M_START;
      end else if (wr_valid) begin
        wr_resp <= 1'b1;
        unique case (mode)
          M_START: begin
            ptr  <= PTR_W'(wr_data[ADDR_W-1:0]);
            mode <= M_WRITE;
          end
          M_WRITE: begin
            if (at_end) wr_nack <= 1'b1;
            else        ptr     <= ptr + 1'b1;
          end
          default: wr_nack <= 1'b1;
        endcase
      end else if (rd_req) begin
        rd_valid <= 1'b1;
        if (mode == M_START || mode == M_READ) begin
          mode <= M_READ;
          if (at_end) begin
            rd_src <= SRC_FF;
          end else begin
            rd_src <= SRC_MEM;
            ptr    <= ptr + 1'b1;
          end
        end else begin
          rd_src <= SRC_ZERO;
        end
      end
    end
  end
endmodule

// File: rtl/ee_byte_store.sv
module ee_byte_store
  import ebs_pkg::*;
#(
  parameter int          ADDR_W    = 8,
  parameter int          DATA_W    = 8,
  parameter int          ID_W      = 3,
  parameter logic [6:0]  ADDR_BASE = 7'h30
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ID_W-1:0]   dev_id,
  output logic [6:0]        tgt_addr,
  input  logic              evt_start,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_resp,
  output logic              wr_nack,
  input  logic              rd_req,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  input  logic [ADDR_W-1:0] host_addr,
  output logic [DATA_W-1:0] host_data
);
  logic              mem_we;
  logic [ADDR_W-1:0] mem_addr;
  logic [DATA_W-1:0] mem_rd;
  rsrc_t             rd_src;
  mode_t             cur_mode;
  logic [ADDR_W:0]   cur_ptr;

  ebs_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst(rst), .evt_start(evt_start), .wr_valid(wr_valid),
    .wr_data(wr_data), .rd_req(rd_req), .wr_resp(wr_resp), .wr_nack(wr_nack),
    .rd_valid(rd_valid), .rd_src(rd_src), .mem_we(mem_we), .mem_addr(mem_addr),
    .mode(cur_mode), .ptr(cur_ptr)
  );

  ebs_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk(clk), .rst(rst), .we(mem_we), .waddr(mem_addr), .wdata(wr_data),
    .raddr_a(mem_addr), .rdata_a(mem_rd),
    .raddr_b(host_addr), .rdata_b(host_data)
  );

  always_comb begin
    unique case (rd_src)
      SRC_MEM: rd_data = mem_rd;
      SRC_FF:  rd_data = '1;
      default: rd_data = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) tgt_addr <= ADDR_BASE;
    else     tgt_addr <= ADDR_BASE + 7'(dev_id);
  end
endmodule

// File: rtl/ebs_chk.sv
module ebs_chk
  import ebs_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int ID_W   = 3
) (
  input logic              clk,
  input logic              rst,
  input logic [ID_W-1:0]   dev_id,
  input logic [6:0]        tgt_addr,
  input logic              evt_start,
  input logic              wr_valid,
  input logic              wr_resp,
  input logic              wr_nack,
  input logic              rd_req,
  input logic              rd_valid,
  input logic [DATA_W-1:0] rd_data,
  input mode_t             mode,
  input logic [ADDR_W:0]   ptr
);
  localparam logic [ADDR_W:0] PTR_END = (ADDR_W+1)'(1) << ADDR_W;

  a_r1_quiet_after_reset: assert property (@(posedge clk)
    rst |=> (!wr_resp && !rd_valid));

  a_r2_addr_stable: assert property (@(posedge clk) disable iff (rst)
    $stable(dev_id) |=> $stable(tgt_addr));

  a_r3_write_answered: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && !evt_start) |=> wr_resp);

  a_r3_read_answered: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !wr_valid && !evt_start) |=> rd_valid);

  a_r6_end_refused: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && !evt_start && mode == M_WRITE && ptr == PTR_END) |=> wr_nack);

  a_r8_ptr_bounded: assert property (@(posedge clk) disable iff (rst)
    ptr <= PTR_END);

  a_r8_end_reads_ff: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !wr_valid && !evt_start && mode == M_READ && ptr == PTR_END)
      |=> (rd_data == '1 && ptr == PTR_END));

  a_r10_read_mode_refuses: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && !evt_start && mode == M_READ) |=> (wr_nack && $stable(ptr)));

  a_r11_start_drops: assert property (@(posedge clk) disable iff (rst)
    evt_start |=> (!wr_resp && !rd_valid && mode == M_START));

  a_r11_one_response: assert property (@(posedge clk) disable iff (rst)
    !(wr_resp && rd_valid));
endmodule

bind ee_byte_store ebs_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_W(ID_W)) u_chk (
  .clk(clk), .rst(rst), .dev_id(dev_id), .tgt_addr(tgt_addr),
  .evt_start(evt_start), .wr_valid(wr_valid), .wr_resp(wr_resp),
  .wr_nack(wr_nack), .rd_req(rd_req), .rd_valid(rd_valid), .rd_data(rd_data),
  .mode(cur_mode), .ptr(cur_ptr)
);

// File: tb/sim_ee_byte_store.sv
`timescale 1ns/1ps
module sim_ee_byte_store;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] dev_id = 3'd0;
  logic [6:0] tgt_addr;
  logic       evt_start = 1'b0;
  logic       wr_valid = 1'b0;
  logic [7:0] wr_data = 8'd0;
  logic       wr_resp, wr_nack;
  logic       rd_req = 1'b0;
  logic       rd_valid;
  logic [7:0] rd_data;
  logic [7:0] host_addr = 8'd0;
  logic [7:0] host_data;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // reference model
  logic [7:0] m_mem [256];
  int         m_ptr;
  int         m_mode; // 0 idle, 1 start, 2 write, 3 read

  always #10 clk = ~clk;

  ee_byte_store u0 (
    .clk(clk), .rst(rst), .dev_id(dev_id), .tgt_addr(tgt_addr),
    .evt_start(evt_start), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_resp(wr_resp), .wr_nack(wr_nack), .rd_req(rd_req),
    .rd_valid(rd_valid), .rd_data(rd_data), .host_addr(host_addr),
    .host_data(host_data)
  );

  task automatic chk(input bit ok, input string rq, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 256; i++) m_mem[i] = 8'h00;
    m_ptr  = 0;
    m_mode = 0;
  endtask

  // one handshake cycle: drive at falling edge, compare at next falling edge
  task automatic step(input bit s, input bit w, input bit r,
                      input logic [7:0] d, input string rq);
    bit         e_wr, e_nack, e_rd;
    logic [7:0] e_data;
    e_wr = 0; e_nack = 0; e_rd = 0; e_data = 8'h00;
    if (s) begin
      m_mode = 1;
    end else if (w) begin
      e_wr = 1;
      if (m_mode == 1) begin
        m_ptr = int'(d); m_mode = 2;
      end else if (m_mode == 2) begin
        if (m_ptr == 256) e_nack = 1;
        else begin m_mem[m_ptr] = d; m_ptr++; end
      end else e_nack = 1;
    end else if (r) begin
      e_rd = 1;
      if (m_mode == 1 || m_mode == 3) begin
        m_mode = 3;
        if (m_ptr == 256) e_data = 8'hFF;
        else begin e_data = m_mem[m_ptr]; m_ptr++; end
      end
    end
    evt_start = s; wr_valid = w; wr_data = d; rd_req = r;
    @(negedge clk);
    evt_start = 0; wr_valid = 0; rd_req = 0;
    chk(wr_resp === e_wr, rq, "wr_resp", int'(wr_resp), int'(e_wr));
    if (e_wr) chk(wr_nack === e_nack, rq, "wr_nack", int'(wr_nack), int'(e_nack));
    chk(rd_valid === e_rd, rq, "rd_valid", int'(rd_valid), int'(e_rd));
    if (e_rd) chk(rd_data === e_data, rq, "rd_data", int'(rd_data), int'(e_data));
  endtask

  task automatic host_peek(input int a, input string rq);
    host_addr = 8'(a);
    @(negedge clk);
    chk(host_data === m_mem[a], rq, "host_data", int'(host_data), int'(m_mem[a]));
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog", "timeout", 0, 1);
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd4242));
    model_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: no responses and zero contents after reset
    chk(!wr_resp && !rd_valid, "R1", "idle responses", int'({wr_resp, rd_valid}), 0);
    for (int i = 0; i < 256; i += 17) host_peek(i, "R1");
    // R2: address follows straps one cycle later
    for (int k = 0; k < 8; k++) begin
      dev_id = 3'(k);
      @(negedge clk);
      chk(tgt_addr === 7'(8'h30 + k), "R2", "tgt_addr", int'(tgt_addr), 8'h30 + k);
    end
    // R10 and R9: idle mode refuses writes and reads zero
    step(0, 1, 0, 8'h55, "R10");
    step(0, 0, 1, 8'h00, "R9");
    // R4, R5: set pointer then store two bytes at the top
    step(1, 0, 0, 8'h00, "R4");
    step(0, 1, 0, 8'hFE, "R4");
    step(0, 1, 0, 8'hA1, "R5");
    step(0, 1, 0, 8'hB2, "R5");
    // R6: pointer at 256, refused and nothing changes
    step(0, 1, 0, 8'hC3, "R6");
    host_peek(255, "R6");
    host_peek(0, "R6");
    // R8: read after start with pointer at the end returns 0xFF twice
    step(1, 0, 0, 8'h00, "R8");
    step(0, 0, 1, 8'h00, "R8");
    step(0, 0, 1, 8'h00, "R8");
    // R9: read in write mode returns zero and keeps the pointer
    step(1, 0, 0, 8'h00, "R9");
    step(0, 1, 0, 8'h10, "R9");
    step(0, 0, 1, 8'h00, "R9");
    step(0, 1, 0, 8'h77, "R9");
    host_peek(16, "R9");
    // R7: read streams from the pointer after start
    step(1, 0, 0, 8'h00, "R7");
    step(0, 1, 0, 8'hFD, "R7");
    step(1, 0, 0, 8'h00, "R7");
    step(0, 0, 1, 8'h00, "R7");
    step(0, 0, 1, 8'h00, "R7");
    step(0, 0, 1, 8'h00, "R7");
    // R10: write in read mode refused
    step(0, 1, 0, 8'h99, "R10");
    step(0, 0, 1, 8'h00, "R10");
    // R11: start swallows same-cycle traffic; write wins over read
    step(1, 1, 1, 8'h20, "R11");
    step(0, 1, 1, 8'h20, "R11");
    step(0, 1, 1, 8'h5A, "R11");
    host_peek(32, "R11");
    // R3, R12: random traffic with host port sweeps in between
    for (int n = 0; n < 3000; n++) begin
      int sel;
      sel = int'($urandom_range(0, 99));
      if (sel < 8)       step(1, 0, 0, 8'h00, "R3");
      else if (sel < 55) step(0, 1, 0, 8'($urandom_range(0, 255)), "R5");
      else if (sel < 95) step(0, 0, 1, 8'h00, "R7");
      else               host_peek(int'($urandom_range(0, 255)), "R12");
    end
    for (int i = 0; i < 256; i++) host_peek(i, "R12");
    done = 1'b1;
    finish_run();
  end
endmodule